// File: doc/BRIEF.md
# Flash Command Decoder

This block is the command front end of a parallel NOR-style flash model. It watches host bus write cycles formed by chip enable and write enable, tracks the multi-write unlock and command sequences, and turns completed sequences into program, sector erase and chip erase jobs. Each job goes to a separate sequencer through a one-cycle start pulse, and the sequencer reports progress on a busy line. The block also supports erase suspend and resume, a shortened program flow for bulk writes, an identifier read mode and a reset command.

Reads are served from one of three sources. Array data comes in from the external storage. Identifier codes come from parameters and a per-sector protect vector. Operation status is shown while a job runs. Commands are gated by the job in progress: a running program or chip erase locks out every write, and a running sector erase accepts only the suspend command.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the decoder is in array read mode: `rdata` equals `arr_q` and no start, suspend or resume pulse is issued.
- R2: Writes of AAh at 555h, 55h at 2AAh and A0h at 555h, followed by one more write, issue one `seq_start` pulse with `seq_op`=1 (program), `seq_addr` and `seq_data` taken from that last write.
- R3: A write that does not match the expected step of a sequence (wrong data or wrong address) returns the decoder to array read, and later writes are decoded from the first step again.
- R4: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at any address issues a start with `seq_op`=2 (sector erase) and `seq_addr` equal to that address.
- R5: The same prefix ended by 10h@555h issues a start with `seq_op`=3 (chip erase) and `seq_addr`=555h.
- R6: After the unlock pair and 20h@555h, the decoder is in bypass mode, where A0h at any address and one more write issue a program start. The pair 90h then 00h leaves bypass mode.
- R7: After the unlock pair and 90h@555h, reads return the manufacturer code when address bits [1:0]=0, the device code when they are 1, and 01h or 00h when they are 2 (the protect bit of the sector in the top address bits).
- R8: While a program or chip erase job is active, every write is ignored: no start, suspend or resume is issued.
- R9: While a sector erase runs, only B0h is accepted. It issues `seq_suspend` and reads then return array data. A later 30h issues `seq_resume` and reads show status again.
- R10: While a job is active and not suspended, reads return status: bit 6 toggles after each read, bit 7 is the inverse of bit 7 of the programmed data (0 for erase), and bits 5:0 are zero.
- R11: Once `seq_busy` has been seen high and then drops, the job ends: reads return array data and the full command set is accepted again.
- R12: A write of F0h in any state other than the program data step, with no job running, returns the decoder to array read.
- R13: A write cycle takes its address when the strobe (CE or WE, whichever is later to go low) falls, and its data when the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Bus address |
| dq_in | input | DW | Bus write data |
| arr_q | input | DW | Array contents at `addr` |
| sect_prot | input | 2**SECT_W | Protect flag for each sector |
| rdata | output | DW | Read data to the bus |
| seq_start | output | 1 | One-cycle job start pulse |
| seq_op | output | 2 | Job type: 1 program, 2 sector erase, 3 chip erase |
| seq_addr | output | AW | Job address |
| seq_data | output | DW | Job data |
| seq_suspend | output | 1 | One-cycle erase suspend pulse |
| seq_resume | output | 1 | One-cycle erase resume pulse |
| seq_busy | input | 1 | Sequencer busy |

## Verification
The assertions check, on every cycle, the lockout rules:
- no start while a job is active;
- suspend only during an unsuspended sector erase;
- at most one control pulse per cycle;
- program starts only from a program-data step.

They also check that each write event follows a strobe release, and that the status and identifier bytes have their fixed shape. The bench scenarios are needed for everything else: the full unlock sequences, rejection of broken or reset sequences, bypass entry and exit, the alternating toggle bit across consecutive reads, the address held through a scrambled bus, and the return to normal decoding after the job ends.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    M_READ, M_U1, M_U2, M_PGM, M_E80, M_E1, M_E2,
    M_ID, M_BYP, M_BPGM, M_BEX
  } mode_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SER  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  localparam logic [7:0] CMD_UNLK1  = 8'hAA;
  localparam logic [7:0] CMD_UNLK2  = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_BYPASS = 8'h20;
  localparam logic [7:0] CMD_RST    = 8'hF0;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_RESUME = 8'h30;
  localparam logic [7:0] CMD_BEXIT  = 8'h00;

  // Status byte: [7] polls complement of programmed bit 7, [6] toggles per read
  function automatic logic [7:0] status_byte(input logic is_prog,
                                             input logic pbit7,
                                             input logic tog);
    return {is_prog ? ~pbit7 : 1'b0, tog, 6'b0};
  endfunction

  // Identifier byte selected by the two low address bits
  function automatic logic [7:0] id_byte(input logic [1:0] sel,
                                         input logic [7:0] mfr,
                                         input logic [7:0] dev,
                                         input logic prot);
    case (sel)
      2'd0:    return mfr;
      2'd1:    return dev;
      2'd2:    return {7'b0, prot};
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_end
);
  logic strobe_n, rdsel_n, stb_q, rd_q;
  logic [AW-1:0] a_lat;
  logic stb_fall, stb_rise;

  assign strobe_n = ce_n | we_n;
  assign rdsel_n  = ce_n | oe_n;
  assign stb_fall = stb_q & ~strobe_n;
  assign stb_rise = ~stb_q & strobe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b1;
      rd_q    <= 1'b1;
      a_lat   <= '0;
      wr_evt  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_end  <= 1'b0;
    end else begin
      stb_q  <= strobe_n;
      rd_q   <= rdsel_n;
      wr_evt <= stb_rise;
      rd_end <= ~rd_q & rdsel_n;
      if (stb_fall) a_lat <= addr;
      if (stb_rise) begin
        wr_addr <= a_lat;
        wr_data <= dq_in;
      end
    end
  end

  // R13
  wr_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> $past(ce_n | we_n));

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter logic [AW-1:0] UNLK_A = 12'h555,
  parameter logic [AW-1:0] UNLK_B = 12'h2AA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          seq_busy,
  output logic          seq_start,
  output logic [1:0]    seq_op,
  output logic [AW-1:0] seq_addr,
  output logic [DW-1:0] seq_data,
  output logic          seq_suspend,
  output logic          seq_resume,
  output logic          job_act,
  output logic          susp,
  output logic          job_prog,
  output logic          pbit7,
  output logic          id_mode
);
  mode_e mode, nxt_mode;
  op_e   job_kind, nxt_op;
  logic  seen_busy, job_done, run, hit_a, hit_b;
  logic [7:0] cmd;

  assign cmd      = wd[7:0];
  assign hit_a    = (wa == UNLK_A);
  assign hit_b    = (wa == UNLK_B);
  assign run      = job_act & ~susp;
  assign job_done = job_act & seen_busy & ~seq_busy;
  assign job_prog = (job_kind == OP_PROG);
  assign id_mode  = (mode == M_ID);

  always_comb begin
    nxt_mode = M_READ;
    nxt_op   = OP_NONE;
    if (mode == M_PGM) begin
      nxt_op = OP_PROG;
    end else if (mode == M_BPGM) begin
      nxt_op   = OP_PROG;
      nxt_mode = M_BYP;
    end else if (cmd != CMD_RST) begin
      case (mode)
        M_READ: if (hit_a && cmd == CMD_UNLK1) nxt_mode = M_U1;
        M_U1:   if (hit_b && cmd == CMD_UNLK2) nxt_mode = M_U2;
        M_U2: if (hit_a) begin
          case (cmd)
            CMD_PROG:   nxt_mode = M_PGM;
            CMD_ERASE:  nxt_mode = M_E80;
            CMD_IDENT:  nxt_mode = M_ID;
            CMD_BYPASS: nxt_mode = M_BYP;
            default:    nxt_mode = M_READ;
          endcase
        end
        M_E80: if (hit_a && cmd == CMD_UNLK1) nxt_mode = M_E1;
        M_E1:  if (hit_b && cmd == CMD_UNLK2) nxt_mode = M_E2;
        M_E2: begin
          if (cmd == CMD_SECT) nxt_op = OP_SER;
          else if (hit_a && cmd == CMD_CHIP) nxt_op = OP_CHIP;
        end
        M_ID:  nxt_mode = M_ID;
        M_BYP: nxt_mode = (cmd == CMD_PROG) ? M_BPGM :
                          (cmd == CMD_IDENT) ? M_BEX : M_BYP;
        M_BEX: nxt_mode = (cmd == CMD_BEXIT) ? M_READ : M_BYP;
        default: nxt_mode = M_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_READ;  job_kind <= OP_NONE;
      job_act <= 1'b0; susp <= 1'b0; seen_busy <= 1'b0; pbit7 <= 1'b0;
      seq_start <= 1'b0; seq_suspend <= 1'b0; seq_resume <= 1'b0;
      seq_op <= '0; seq_addr <= '0; seq_data <= '0;
    end else begin
      seq_start   <= 1'b0;
      seq_suspend <= 1'b0;
      seq_resume  <= 1'b0;
      if (job_act && seq_busy) seen_busy <= 1'b1;
      if (job_done) begin
        job_act <= 1'b0; susp <= 1'b0; seen_busy <= 1'b0; job_kind <= OP_NONE;
      end else if (wr_evt) begin
        if (run) begin
          if (job_kind == OP_SER && cmd == CMD_SUSP) begin
            susp <= 1'b1; seq_suspend <= 1'b1; mode <= M_READ;
          end
        end else if (job_act) begin
          if (cmd == CMD_RESUME) begin
            susp <= 1'b0; seq_resume <= 1'b1;
          end
        end else begin
          mode <= nxt_mode;
          if (nxt_op != OP_NONE) begin
            seq_start <= 1'b1; seq_op <= nxt_op; seq_addr <= wa; seq_data <= wd;
            job_act <= 1'b1; job_kind <= nxt_op; pbit7 <= wd[7]; seen_busy <= 1'b0;
          end
        end
      end
    end
  end

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> (job_act && $past(!job_act)));
  // R9
  suspend_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_suspend |-> (susp && job_kind == OP_SER));
  // R9
  ctl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seq_start, seq_suspend, seq_resume}));
  // R2
  prog_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && seq_op == OP_PROG) |-> ($past(mode) == M_PGM || $past(mode) == M_BPGM));

endmodule

// File: rtl/flash_rd_path.sv
module flash_rd_path
  import flash_cmd_pkg::*;
#(
  parameter int DW = 8,
  parameter int SECT_W = 3,
  parameter logic [DW-1:0] MFR_CODE = 8'h5A,
  parameter logic [DW-1:0] DEV_CODE = 8'hB9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_end,
  input  logic                   job_start,
  input  logic                   job_act,
  input  logic                   susp,
  input  logic                   job_prog,
  input  logic                   pbit7,
  input  logic                   id_mode,
  input  logic [1:0]             id_sel,
  input  logic [SECT_W-1:0]      sect_idx,
  input  logic [(1<<SECT_W)-1:0] sect_prot,
  input  logic [DW-1:0]          arr_q,
  output logic [DW-1:0]          rdata
);
  logic tog, status_on;

  assign status_on = job_act & ~susp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tog <= 1'b0;
    else if (job_start)            tog <= 1'b0;
    else if (rd_end && status_on)  tog <= ~tog;
  end

  always_comb begin
    rdata = '0;
    if (status_on)
      rdata[7:0] = status_byte(job_prog, pbit7, tog);
    else if (id_mode)
      rdata[7:0] = id_byte(id_sel, MFR_CODE[7:0], DEV_CODE[7:0], sect_prot[sect_idx]);
    else
      rdata = arr_q;
  end

  // R10
  status_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_on |-> (rdata[5:0] == 6'd0));
  // R7
  id_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && !job_act && id_sel == 2'd0) |-> (rdata == MFR_CODE));

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if #(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter int SECT_W = 3,
  parameter logic [AW-1:0] UNLK_A = 12'h555,
  parameter logic [AW-1:0] UNLK_B = 12'h2AA,
  parameter logic [DW-1:0] MFR_CODE = 8'h5A,
  parameter logic [DW-1:0] DEV_CODE = 8'hB9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_n,
  input  logic                   we_n,
  input  logic                   oe_n,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          dq_in,
  input  logic [DW-1:0]          arr_q,
  input  logic [(1<<SECT_W)-1:0] sect_prot,
  output logic [DW-1:0]          rdata,
  output logic                   seq_start,
  output logic [1:0]             seq_op,
  output logic [AW-1:0]          seq_addr,
  output logic [DW-1:0]          seq_data,
  output logic                   seq_suspend,
  output logic                   seq_resume,
  input  logic                   seq_busy
);
  logic          wr_evt, rd_end;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          job_act, susp, job_prog, pbit7, id_mode;

  flash_bus_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_end(rd_end));

  flash_cmd_fsm #(.AW(AW), .DW(DW), .UNLK_A(UNLK_A), .UNLK_B(UNLK_B)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wa(wr_addr), .wd(wr_data),
    .seq_busy(seq_busy), .seq_start(seq_start), .seq_op(seq_op),
    .seq_addr(seq_addr), .seq_data(seq_data), .seq_suspend(seq_suspend),
    .seq_resume(seq_resume), .job_act(job_act), .susp(susp),
    .job_prog(job_prog), .pbit7(pbit7), .id_mode(id_mode));

  flash_rd_path #(.DW(DW), .SECT_W(SECT_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_end(rd_end), .job_start(seq_start),
    .job_act(job_act), .susp(susp), .job_prog(job_prog), .pbit7(pbit7),
    .id_mode(id_mode), .id_sel(addr[1:0]), .sect_idx(addr[AW-1 -: SECT_W]),
    .sect_prot(sect_prot), .arr_q(arr_q), .rdata(rdata));

endmodule

// File: tb/sim_flash_cmd_if.sv
module sim_flash_cmd_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic [11:0] addr = '0;
  logic [7:0]  dq = '0;
  logic [7:0]  arr_q;
  logic [7:0]  sect_prot = 8'b0010_0000;
  logic [7:0]  rdata;
  logic        seq_start, seq_suspend, seq_resume;
  logic [1:0]  seq_op;
  logic [11:0] seq_addr;
  logic [7:0]  seq_data;
  logic        seq_busy = 1'b0;

  int checks = 0;
  int errors = 0;

  typedef struct packed { logic [2:0] kind; logic [11:0] a; logic [7:0] d; } ev_t;
  ev_t   exp_q[$];
  string req_q[$];
  ev_t   got, want;
  string wreq;

  always #2 clk = ~clk;

  assign arr_q = addr[7:0] ^ 8'h3C;

  flash_cmd_if u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq), .arr_q(arr_q), .sect_prot(sect_prot),
    .rdata(rdata), .seq_start(seq_start), .seq_op(seq_op),
    .seq_addr(seq_addr), .seq_data(seq_data), .seq_suspend(seq_suspend),
    .seq_resume(seq_resume), .seq_busy(seq_busy));

  // Monitor: pops expected sequencer events and compares
  always @(negedge clk) begin
    if (rst_n && (seq_start || seq_suspend || seq_resume)) begin
      got.kind = seq_start ? {1'b0, seq_op} : (seq_suspend ? 3'd4 : 3'd5);
      got.a = seq_addr;
      got.d = seq_data;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected event: actual kind %0d addr %h, expected none", got.kind, got.a);
      end else begin
        want = exp_q.pop_front();
        wreq = req_q.pop_front();
        if (got.kind != want.kind ||
            (got.kind <= 3'd3 && got.a != want.a) ||
            (got.kind == 3'd1 && got.d != want.d)) begin
          errors++;
          $display("FAIL %s: actual kind %0d addr %h data %h, expected kind %0d addr %h data %h",
                   wreq, got.kind, got.a, got.d, want.kind, want.a, want.d);
        end
      end
    end
  end

  task automatic push_ev(input logic [2:0] k, input logic [11:0] a, input logic [7:0] d, input string r);
    exp_q.push_back('{kind: k, a: a, d: d});
    req_q.push_back(r);
  endtask

  task automatic bw(input logic [11:0] a, input logic [7:0] d, input bit scramble = 1'b0);
    addr = a; dq = 8'hEE;
    @(negedge clk); we_n = 1'b0;
    repeat (2) @(negedge clk);
    if (scramble) addr = 12'hFFF;
    dq = d;
    @(negedge clk); we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic unlock();
    bw(12'h555, 8'hAA);
    bw(12'h2AA, 8'h55);
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [7:0] expv, input logic [7:0] mask, input string r);
    addr = a;
    @(negedge clk); oe_n = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if ((rdata & mask) != (expv & mask)) begin
      errors++;
      $display("FAIL %s: read %h actual %h expected %h (mask %h)", r, a, rdata, expv, mask);
    end
    oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_arr(input logic [11:0] a, input string r);
    rd_chk(a, a[7:0] ^ 8'h3C, 8'hFF, r);
  endtask

  task automatic drained(input string r);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: pending events actual %0d expected 0", r, exp_q.size());
      exp_q.delete(); req_q.delete();
    end
  endtask

  task automatic pulse_busy();
    seq_busy = 1'b1;
    repeat (4) @(negedge clk);
    seq_busy = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    rd_arr(12'h0A5, "R1");
    drained("R1");

    // R2 R13: program with address scrambled after strobe fall
    push_ev(3'd1, 12'h123, 8'h4D, "R2");
    unlock(); bw(12'h555, 8'hA0); bw(12'h123, 8'h4D, 1'b1);
    drained("R13");
    seq_busy = 1'b1;
    repeat (2) @(negedge clk);
    // R10: status, bit7 = ~0 = 1, toggle alternates
    rd_chk(12'h123, 8'h80, 8'hFF, "R10");
    rd_chk(12'h123, 8'hC0, 8'hFF, "R10");
    // R8: commands ignored during program
    bw(12'h000, 8'hB0);
    unlock(); bw(12'h555, 8'hA0); bw(12'h050, 8'h11);
    bw(12'h000, 8'hF0);
    drained("R8");
    rd_chk(12'h050, 8'h80, 8'hBF, "R8");
    seq_busy = 1'b0;
    repeat (3) @(negedge clk);
    // R11: array again and full command set
    rd_arr(12'h050, "R11");
    push_ev(3'd1, 12'h0F0, 8'hC5, "R11");
    unlock(); bw(12'h555, 8'hA0); bw(12'h0F0, 8'hC5);
    seq_busy = 1'b1;
    repeat (2) @(negedge clk);
    rd_chk(12'h0F0, 8'h00, 8'hFF, "R10");
    seq_busy = 1'b0;
    repeat (3) @(negedge clk);
    drained("R11");

    // R3: broken sequences
    bw(12'h555, 8'hAA); bw(12'h123, 8'h55); bw(12'h555, 8'hA0); bw(12'h010, 8'h77);
    unlock(); bw(12'h555, 8'h77); bw(12'h020, 8'h66);
    drained("R3");
    rd_arr(12'h010, "R3");

    // R12: reset mid-sequence
    unlock(); bw(12'h000, 8'hF0); bw(12'h555, 8'hA0); bw(12'h222, 8'h11);
    drained("R12");
    rd_arr(12'h222, "R12");

    // R4 R9: sector erase, suspend, resume
    push_ev(3'd2, 12'hA40, 8'h30, "R4");
    unlock(); bw(12'h555, 8'h80); unlock(); bw(12'hA40, 8'h30);
    seq_busy = 1'b1;
    repeat (2) @(negedge clk);
    rd_chk(12'hA40, 8'h00, 8'hFF, "R10");
    rd_chk(12'hA40, 8'h40, 8'hFF, "R10");
    unlock(); bw(12'h555, 8'hA0); bw(12'h050, 8'h99);
    drained("R9");
    push_ev(3'd4, 12'h000, 8'h00, "R9");
    bw(12'h000, 8'hB0);
    rd_arr(12'h0AB, "R9");
    push_ev(3'd5, 12'h000, 8'h00, "R9");
    bw(12'h000, 8'h30);
    rd_chk(12'hA40, 8'h00, 8'hFF, "R9");
    seq_busy = 1'b0;
    repeat (3) @(negedge clk);
    drained("R4");
    rd_arr(12'hA40, "R11");

    // R5: chip erase, suspend ignored
    push_ev(3'd3, 12'h555, 8'h10, "R5");
    unlock(); bw(12'h555, 8'h80); unlock(); bw(12'h555, 8'h10);
    seq_busy = 1'b1;
    repeat (2) @(negedge clk);
    bw(12'h000, 8'hB0);
    drained("R5");
    rd_chk(12'h000, 8'h00, 8'hBF, "R8");
    seq_busy = 1'b0;
    repeat (3) @(negedge clk);

    // R6: bypass mode
    unlock(); bw(12'h555, 8'h20);
    push_ev(3'd1, 12'h300, 8'h12, "R6");
    bw(12'h000, 8'hA0); bw(12'h300, 8'h12);
    pulse_busy();
    push_ev(3'd1, 12'h301, 8'h34, "R6");
    bw(12'h000, 8'hA0); bw(12'h301, 8'h34);
    pulse_busy();
    drained("R6");
    bw(12'h000, 8'h90); bw(12'h000, 8'h00);
    bw(12'h000, 8'hA0); bw(12'h302, 8'h56);
    drained("R6");
    rd_arr(12'h302, "R6");

    // R7: identifier mode
    unlock(); bw(12'h555, 8'h90);
    rd_chk(12'h000, 8'h5A, 8'hFF, "R7");
    rd_chk(12'h001, 8'hB9, 8'hFF, "R7");
    rd_chk(12'hA02, 8'h01, 8'hFF, "R7");
    rd_chk(12'h402, 8'h00, 8'hFF, "R7");
    bw(12'h000, 8'hF0);
    rd_arr(12'h001, "R12");
    drained("R7");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule